// File: doc/BRIEF.md
# Reload/Capture Timer with Pin Timestamping and Clock Output

This block is a 16-bit up-counter with a companion 16-bit register that either supplies the reload value or receives a captured count. It has two external inputs. The trigger pin can reload or capture the counter. The count pin can clock the counter or provide timestamps. Each pin passes through a two-flop synchroniser before any edge on it is acted upon. The internal count rate comes from a prescaler that divides the system clock by 12, 4 or 1. In counter mode the count pin clocks the counter instead.

The operating mode is selected combinationally from the configuration inputs, and there are three modes:

- MODE_BAUD is selected whenever either serial-clock select is high. It has the highest priority.
- MODE_CAPTURE is selected when the capture select is high.
- MODE_RELOAD is selected otherwise.

The mode follows the configuration in the same cycle, so any mode can move to any other.

A second capture channel copies the counter into a read-only register on a chosen edge of the count pin. A toggle output provides a square wave at half the overflow rate. A one-cycle overflow pulse is provided for a serial port. Software writes and flag clears arrive as plain strobes, because bus decoding lives outside this block.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, the following are all 0: count_q, reload_q, pin_cap_q, every flag, baud_tick and clk_out.
- R2: With ext_count_sel low and run_en high, the counter advances once every 12 clocks when fast_clk_sel is 0 (whatever fastest_clk_sel is), once every 4 clocks when fast_clk_sel=1 and fastest_clk_sel=0, and every clock when both are 1. The first step comes that many clocks after run_en rises. With run_en low the counter holds and the prescaler restarts.
- R3: An increment at 16'hFFFF is an overflow. In MODE_RELOAD the counter loads reload_q; in MODE_CAPTURE it wraps to 0. In both modes ovf_flag is set.
- R4: In MODE_RELOAD, a falling edge on trig_pin with trig_en=1 loads reload_q into the counter and sets ext_flag. With trig_en=0 the edge changes neither the counter nor ext_flag.
- R5: In MODE_CAPTURE, a falling trig_pin edge with trig_en=1 copies count_q into reload_q and sets ext_flag; the counter is not disturbed.
- R6: In MODE_BAUD:
  - ovf_flag is never set.
  - capture is off, so a trigger edge neither captures nor reloads, although it still sets ext_flag.
  - an overflow reloads the counter.
  - baud_tick is high for exactly the one cycle after each overflow.
- R7: ovf_flag, ext_flag and cap_flag stay set until their clear strobe (clr_ovf, clr_ext, clr_cap); a set in the same cycle wins over a clear.
- R8: cap_edge_mode selects the count-pin capture edge: bit0=0 means falling edge, 2'b01 means any edge, 2'b11 means rising edge. A matching edge copies count_q into pin_cap_q and sets cap_flag.
- R9: Count-pin capture happens only when all of the following hold: pin_cap_en=1, not MODE_BAUD, capture_sel=1, ext_count_sel=0 and clk_out_en=0. Otherwise pin_cap_q and cap_flag are left untouched.
- R10: With clk_out_en=1, clk_out inverts on every overflow. Otherwise it holds its level.
- R11: With ext_count_sel=1 and run_en=1, each falling edge of count_pin advances the counter. Every pin edge takes effect at the third rising clock edge after the pin changes.
- R12: When a reload and an increment fall in the same cycle, the counter takes the reload value.
- R13: count_wr and reload_wr load their data at the next clock edge and take priority over every hardware update of the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter run enable |
| ext_count_sel | input | 1 | 1 = count falling edges of count_pin, 0 = internal tick |
| capture_sel | input | 1 | 1 = trigger captures, 0 = trigger reloads |
| trig_en | input | 1 | Enables the trigger-pin function |
| cap_edge_mode | input | 2 | Count-pin capture edge code |
| pin_cap_en | input | 1 | Enables capture from count_pin |
| clk_out_en | input | 1 | Enables the overflow toggle output |
| baud_rx_sel | input | 1 | Timer supplies the serial receive clock |
| baud_tx_sel | input | 1 | Timer supplies the serial transmit clock |
| fast_clk_sel | input | 1 | Fast prescale (divide by 4) |
| fastest_clk_sel | input | 1 | With fast_clk_sel, no division |
| trig_pin | input | 1 | Trigger pin, asynchronous |
| count_pin | input | 1 | Count / capture pin, asynchronous |
| count_wr | input | 1 | Software write strobe for the counter |
| count_wdata | input | 16 | Counter write data |
| reload_wr | input | 1 | Software write strobe for reload_q |
| reload_wdata | input | 16 | Reload register write data |
| clr_ovf | input | 1 | Clear ovf_flag |
| clr_ext | input | 1 | Clear ext_flag |
| clr_cap | input | 1 | Clear cap_flag |
| count_q | output | 16 | Counter value |
| reload_q | output | 16 | Reload / trigger-capture register |
| pin_cap_q | output | 16 | Count-pin capture register |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | Trigger-edge flag |
| cap_flag | output | 1 | Count-pin capture flag |
| baud_tick | output | 1 | One-cycle overflow pulse in MODE_BAUD |
| clk_out | output | 1 | Square wave at half the overflow rate |

## Verification
Several properties are checked on every cycle:
- the overflow flag stays clear in MODE_BAUD.
- flags stay set until they are cleared.
- a reload always beats an increment.
- clk_out holds unless an enabled overflow occurs.
- the counter stays put when nothing should move it.
- a matching count-pin edge always raises cap_flag, and a disarmed capture path leaves pin_cap_q alone.
- the prescaler never ticks twice in a row when it divides.

Only the bench scenarios can show the exact division ratios, the three-edge pin latency and the edge-code decoding against independent arithmetic. The same holds for the value captured in each mode and the toggle sequence of clk_out.

// File: rtl/crt_pkg.sv
package crt_pkg;

    typedef enum logic [1:0] {
        MODE_RELOAD  = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_BAUD    = 2'd2
    } crt_mode_e;

    // Edge code: bit0 = 0 -> falling, 2'b01 -> any, 2'b11 -> rising
    function automatic logic edge_match(input logic [1:0] sel,
                                        input logic       rise,
                                        input logic       fall);
        if (!sel[0])
            return fall;
        else if (sel[1])
            return rise;
        else
            return rise | fall;
    endfunction

endpackage

// File: rtl/crt_pin_sync.sv
module crt_pin_sync #(
    parameter int   PINS        = 2,
    parameter int   STAGES      = 2,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_i,
    output logic [PINS-1:0] rise_o,
    output logic [PINS-1:0] fall_o
);

    localparam int CHAIN = STAGES + 1;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic [CHAIN-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chain_q <= {CHAIN{RESET_LEVEL}};
            else
                chain_q <= {chain_q[CHAIN-2:0], pin_i[p]};
        end

        assign rise_o[p] =  chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall_o[p] = ~chain_q[STAGES-1] &  chain_q[STAGES];
    end

endmodule

// File: rtl/crt_prescale.sv
module crt_prescale #(
    parameter int DIV_STD  = 12,
    parameter int DIV_FAST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fast_sel_i,
    input  logic fastest_sel_i,
    output logic tick_o
);

    localparam int CW = $clog2(DIV_STD);

    logic [CW-1:0] pre_q;
    logic [CW-1:0] lim;
    logic          wrap;

    always_comb begin
        if (!fast_sel_i)
            lim = CW'(DIV_STD - 1);
        else if (fastest_sel_i)
            lim = '0;
        else
            lim = CW'(DIV_FAST - 1);
    end

    assign wrap   = (pre_q >= lim);
    assign tick_o = run_i & wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!run_i || wrap)
            pre_q <= '0;
        else
            pre_q <= pre_q + CW'(1);
    end

    // R2: a dividing prescaler never issues back-to-back ticks
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !(fast_sel_i && fastest_sel_i))
            |=> (!tick_o || (fast_sel_i && fastest_sel_i)));

endmodule

// File: rtl/crt_pin_capture.sv
module crt_pin_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm_i,
    input  logic [1:0]   edge_sel_i,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic [W-1:0] count_i,
    input  logic         clr_i,
    output logic [W-1:0] cap_q_o,
    output logic         flag_o
);

    import crt_pkg::*;

    logic hit;

    assign hit = arm_i & edge_match(edge_sel_i, rise_i, fall_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q_o <= '0;
            flag_o  <= 1'b0;
        end else begin
            if (hit)
                cap_q_o <= count_i;
            flag_o <= hit | (flag_o & ~clr_i);
        end
    end

    // R8: a matching edge always raises the flag
    a_r8_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_o);

    // R9: a disarmed channel leaves its register untouched
    a_r9_disarmed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> $stable(cap_q_o));

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
    parameter int CNT_W    = 16,
    parameter int DIV_STD  = 12,
    parameter int DIV_FAST = 4,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             ext_count_sel,
    input  logic             capture_sel,
    input  logic             trig_en,
    input  logic [1:0]       cap_edge_mode,
    input  logic             pin_cap_en,
    input  logic             clk_out_en,
    input  logic             baud_rx_sel,
    input  logic             baud_tx_sel,
    input  logic             fast_clk_sel,
    input  logic             fastest_clk_sel,
    input  logic             trig_pin,
    input  logic             count_pin,
    input  logic             count_wr,
    input  logic [CNT_W-1:0] count_wdata,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             clr_ovf,
    input  logic             clr_ext,
    input  logic             clr_cap,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] pin_cap_q,
    output logic             ovf_flag,
    output logic             ext_flag,
    output logic             cap_flag,
    output logic             baud_tick,
    output logic             clk_out
);

    import crt_pkg::*;

    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam int PIN_TRIG = 0;
    localparam int PIN_CNT  = 1;

    // Pin synchronisers (trigger pin, count pin)
    logic [1:0] pin_rise, pin_fall;
    logic       trig_rise_unused;

    crt_pin_sync #(
        .PINS        (2),
        .STAGES      (SYNC_LEN),
        .RESET_LEVEL (1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({count_pin, trig_pin}),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign trig_rise_unused = pin_rise[PIN_TRIG];

    // Internal tick
    logic tick;

    crt_prescale #(
        .DIV_STD  (DIV_STD),
        .DIV_FAST (DIV_FAST)
    ) u_pre (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run_en & ~ext_count_sel),
        .fast_sel_i    (fast_clk_sel),
        .fastest_sel_i (fastest_clk_sel),
        .tick_o        (tick)
    );

    // Mode selection
    crt_mode_e mode;
    logic      baud_mode;

    assign baud_mode = baud_rx_sel | baud_tx_sel;

    always_comb begin
        if (baud_mode)
            mode = MODE_BAUD;
        else if (capture_sel)
            mode = MODE_CAPTURE;
        else
            mode = MODE_RELOAD;
    end

    // Events
    logic inc, ovf, trig_evt;
    logic reload_evt, capture_evt, ovf_set;

    assign inc      = run_en & (ext_count_sel ? pin_fall[PIN_CNT] : tick);
    assign ovf      = inc & (count_q == ALL_ONES);
    assign trig_evt = trig_en & pin_fall[PIN_TRIG];

    always_comb begin
        reload_evt  = 1'b0;
        capture_evt = 1'b0;
        ovf_set     = 1'b0;
        unique case (mode)
            MODE_RELOAD: begin
                reload_evt = ovf | trig_evt;
                ovf_set    = ovf;
            end
            MODE_CAPTURE: begin
                capture_evt = trig_evt;
                ovf_set     = ovf;
            end
            MODE_BAUD: begin
                reload_evt = ovf;
            end
            default: begin
                reload_evt = 1'b0;
            end
        endcase
    end

    // Counter and reload/capture register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (count_wr)
            count_q <= count_wdata;
        else if (reload_evt)
            count_q <= reload_q;
        else if (inc)
            count_q <= count_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reload_q <= '0;
        else if (reload_wr)
            reload_q <= reload_wdata;
        else if (capture_evt)
            reload_q <= count_q;
    end

    // Flags, serial pulse, toggle output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag  <= 1'b0;
            ext_flag  <= 1'b0;
            baud_tick <= 1'b0;
            clk_out   <= 1'b0;
        end else begin
            ovf_flag  <= ovf_set  | (ovf_flag & ~clr_ovf);
            ext_flag  <= trig_evt | (ext_flag & ~clr_ext);
            baud_tick <= ovf & baud_mode;
            if (ovf && clk_out_en)
                clk_out <= ~clk_out;
        end
    end

    // Count-pin capture channel
    logic pin_arm;

    assign pin_arm = pin_cap_en & ~baud_mode & capture_sel
                   & ~ext_count_sel & ~clk_out_en;

    crt_pin_capture #(
        .W (CNT_W)
    ) u_pcap (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (pin_arm),
        .edge_sel_i (cap_edge_mode),
        .rise_i     (pin_rise[PIN_CNT]),
        .fall_i     (pin_fall[PIN_CNT]),
        .count_i    (count_q),
        .clr_i      (clr_cap),
        .cap_q_o    (pin_cap_q),
        .flag_o     (cap_flag)
    );

    // R6: the overflow flag cannot rise while serving as a serial clock
    a_r6_baud_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_mode && !ovf_flag) |=> !ovf_flag);

    // R12: a reload beats any increment in the same cycle
    a_r12_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_evt && !count_wr) |=> (count_q == $past(reload_q)));

    // R10: clk_out moves only on an enabled overflow
    a_r10_clkout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && clk_out_en) |=> $stable(clk_out));

    // R7: flags are sticky until cleared
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    a_r7_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flag && !clr_ext) |=> ext_flag);

    // R4: without trigger, write or increment the counter stays put
    a_r4_quiet_counter: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_en && !count_wr && !inc) |=> $stable(count_q));

endmodule

// File: tb/cap_reload_timer_bench.sv
module cap_reload_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en, ext_count_sel, capture_sel, trig_en;
    logic [1:0]  cap_edge_mode;
    logic        pin_cap_en, clk_out_en, baud_rx_sel, baud_tx_sel;
    logic        fast_clk_sel, fastest_clk_sel, trig_pin, count_pin;
    logic        count_wr, reload_wr, clr_ovf, clr_ext, clr_cap;
    logic [15:0] count_wdata, reload_wdata;
    logic [15:0] count_q, reload_q, pin_cap_q;
    logic        ovf_flag, ext_flag, cap_flag, baud_tick, clk_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_reload_timer u_cap_reload_timer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ext_count_sel(ext_count_sel),
        .capture_sel(capture_sel), .trig_en(trig_en), .cap_edge_mode(cap_edge_mode),
        .pin_cap_en(pin_cap_en), .clk_out_en(clk_out_en), .baud_rx_sel(baud_rx_sel),
        .baud_tx_sel(baud_tx_sel), .fast_clk_sel(fast_clk_sel),
        .fastest_clk_sel(fastest_clk_sel), .trig_pin(trig_pin), .count_pin(count_pin),
        .count_wr(count_wr), .count_wdata(count_wdata), .reload_wr(reload_wr),
        .reload_wdata(reload_wdata), .clr_ovf(clr_ovf), .clr_ext(clr_ext),
        .clr_cap(clr_cap), .count_q(count_q), .reload_q(reload_q),
        .pin_cap_q(pin_cap_q), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
        .cap_flag(cap_flag), .baud_tick(baud_tick), .clk_out(clk_out)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_count(input logic [15:0] v);
        count_wr = 1'b1; count_wdata = v; step(1); count_wr = 1'b0;
    endtask

    task automatic wr_reload(input logic [15:0] v);
        reload_wr = 1'b1; reload_wdata = v; step(1); reload_wr = 1'b0;
    endtask

    task automatic clear_all();
        clr_ovf = 1'b1; clr_ext = 1'b1; clr_cap = 1'b1; step(1);
        clr_ovf = 1'b0; clr_ext = 1'b0; clr_cap = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev_cap;
        logic        c0;
        rst_n = 1'b0; run_en = 0; ext_count_sel = 0; capture_sel = 0; trig_en = 0;
        cap_edge_mode = 2'b00; pin_cap_en = 0; clk_out_en = 0; baud_rx_sel = 0;
        baud_tx_sel = 0; fast_clk_sel = 0; fastest_clk_sel = 0; trig_pin = 1;
        count_pin = 1; count_wr = 0; reload_wr = 0; clr_ovf = 0; clr_ext = 0;
        clr_cap = 0; count_wdata = '0; reload_wdata = '0;
        @(negedge clk);
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        chk("R1 count_q", count_q, 0);
        chk("R1 reload_q", reload_q, 0);
        chk("R1 pin_cap_q", pin_cap_q, 0);
        chk("R1 flags", {ovf_flag, ext_flag, cap_flag}, 0);
        chk("R1 baud_tick/clk_out", {baud_tick, clk_out}, 0);

        // R2: prescale sweep over every select combination
        for (int c = 0; c < 4; c++) begin
            int div;
            div = (c == 3) ? 1 : ((c == 2) ? 4 : 12);
            run_en = 0;
            fast_clk_sel = (c >= 2);
            fastest_clk_sel = c[0];
            wr_count(16'h0000);
            run_en = 1;
            for (int m = 1; m <= 2 * div + 2; m++) begin
                step(1);
                chk("R2 prescaled count", count_q, m / div);
            end
            run_en = 0;
            step(4);
            chk("R2 hold when stopped", count_q, (2 * div + 2) / div);
        end

        // R3: overflow reload in MODE_RELOAD (fastest tick)
        wr_reload(16'h1234);
        wr_count(16'hFFF0);
        run_en = 1;
        step(15);
        chk("R3 count before overflow", count_q, 16'hFFFF);
        chk("R3 no flag before overflow", ovf_flag, 0);
        step(1);
        chk("R3 reload on overflow", count_q, 16'h1234);
        chk("R3 ovf_flag set", ovf_flag, 1);
        run_en = 0;
        step(5);
        chk("R7 ovf_flag sticky", ovf_flag, 1);
        clr_ovf = 1; step(1); clr_ovf = 0;
        chk("R7 ovf_flag cleared", ovf_flag, 0);

        // R3: wrap in MODE_CAPTURE
        capture_sel = 1;
        wr_count(16'hFFFE);
        run_en = 1;
        step(2);
        run_en = 0;
        chk("R3 capture-mode wrap", count_q, 16'h0000);
        chk("R3 capture-mode ovf_flag", ovf_flag, 1);
        chk("R3 reload_q untouched", reload_q, 16'h1234);
        clear_all();
        capture_sel = 0;

        // R6: MODE_BAUD overflow behaviour
        baud_tx_sel = 1;
        wr_count(16'hFFFD);
        run_en = 1;
        step(2);
        chk("R6 count before overflow", count_q, 16'hFFFF);
        chk("R6 no pulse yet", baud_tick, 0);
        step(1);
        chk("R6 reload on overflow", count_q, 16'h1234);
        chk("R6 baud_tick pulse", baud_tick, 1);
        chk("R6 ovf_flag suppressed", ovf_flag, 0);
        step(1);
        chk("R6 baud_tick one cycle", baud_tick, 0);
        run_en = 0;

        // R6: trigger in MODE_BAUD with capture selected
        capture_sel = 1; trig_en = 1;
        wr_count(16'h0777);
        trig_pin = 0; step(3);
        chk("R6 no capture in baud", reload_q, 16'h1234);
        chk("R6 no trigger reload in baud", count_q, 16'h0777);
        chk("R6 ext_flag still set", ext_flag, 1);
        trig_pin = 1; step(3);
        clear_all();
        baud_tx_sel = 0; capture_sel = 0;

        // R4: trigger ignored without trig_en
        trig_en = 0;
        wr_count(16'h0042);
        trig_pin = 0; step(3);
        chk("R4 disabled trigger count", count_q, 16'h0042);
        chk("R4 disabled trigger flag", ext_flag, 0);
        trig_pin = 1; step(3);

        // R4/R11: enabled trigger reload with three-edge latency
        trig_en = 1;
        trig_pin = 0; step(2);
        chk("R11 trigger not yet acted", count_q, 16'h0042);
        step(1);
        chk("R4 trigger reload", count_q, 16'h1234);
        chk("R4 ext_flag", ext_flag, 1);
        trig_pin = 1; step(3);
        clear_all();

        // R5: trigger capture
        capture_sel = 1;
        wr_count(16'h5555);
        trig_pin = 0; step(3);
        chk("R5 captured into reload_q", reload_q, 16'h5555);
        chk("R5 counter undisturbed", count_q, 16'h5555);
        chk("R5 ext_flag", ext_flag, 1);
        trig_pin = 1; step(3);
        clear_all();
        capture_sel = 0;

        // R12: reload coincides with increment
        wr_reload(16'h2000);
        wr_count(16'h0100);
        run_en = 1; trig_pin = 0;
        step(3);
        chk("R12 reload beats increment", count_q, 16'h2000);
        step(1);
        chk("R12 counting resumes", count_q, 16'h2001);
        run_en = 0; trig_pin = 1; step(3);
        clear_all();
        trig_en = 0;

        // R8: sweep of edge codes against both pin directions
        capture_sel = 1; pin_cap_en = 1;
        prev_cap = 16'h0000;
        for (int code = 0; code < 4; code++) begin
            for (int dir = 0; dir < 2; dir++) begin
                logic [15:0] val;
                logic        exp_hit;
                logic [1:0]  cv;
                cv = 2'(code);
                cap_edge_mode = cv;
                val = 16'(code * 16'h1000 + dir * 16'h0010 + 16'h0003);
                wr_count(val);
                clr_cap = 1; step(1); clr_cap = 0;
                count_pin = (dir == 1);
                step(3);
                if (!cv[0])      exp_hit = (dir == 0);
                else if (cv[1])  exp_hit = (dir == 1);
                else             exp_hit = 1'b1;
                if (exp_hit) prev_cap = val;
                chk("R8 cap_flag by edge code", cap_flag, exp_hit);
                chk("R8 pin_cap_q by edge code", pin_cap_q, prev_cap);
                step(2);
            end
        end

        // R9: every blocking condition leaves the channel idle
        cap_edge_mode = 2'b01;
        wr_count(16'hBEEF);
        clear_all();
        for (int g = 0; g < 5; g++) begin
            case (g)
                0: clk_out_en = 1;
                1: capture_sel = 0;
                2: ext_count_sel = 1;
                3: baud_rx_sel = 1;
                default: pin_cap_en = 0;
            endcase
            step(1);
            count_pin = ~count_pin;
            step(3);
            chk("R9 blocked capture flag", cap_flag, 0);
            chk("R9 blocked capture value", pin_cap_q, prev_cap);
            clk_out_en = 0; capture_sel = 1; ext_count_sel = 0;
            baud_rx_sel = 0; pin_cap_en = 1;
            step(1);
        end
        count_pin = ~count_pin;
        step(3);
        chk("R9 armed capture flag", cap_flag, 1);
        chk("R9 armed capture value", pin_cap_q, 16'hBEEF);
        clear_all();
        pin_cap_en = 0; capture_sel = 0;

        // R11: external counting on falling edges
        count_pin = 1; step(4);
        ext_count_sel = 1;
        wr_count(16'h0000);
        run_en = 1;
        for (int i = 1; i <= 5; i++) begin
            count_pin = 0; step(2);
            chk("R11 edge latency", count_q, i - 1);
            step(1);
            chk("R11 external count", count_q, i);
            count_pin = 1; step(3);
        end
        run_en = 0; ext_count_sel = 0;

        // R10: clock output toggles every overflow
        wr_reload(16'hFFFE);
        wr_count(16'hFFFE);
        clk_out_en = 1;
        c0 = clk_out;
        run_en = 1;
        for (int k = 1; k <= 8; k++) begin
            step(1);
            chk("R10 clk_out toggle", clk_out, c0 ^ ((k / 2) % 2 == 1));
        end
        c0 = clk_out;
        clk_out_en = 0;
        step(6);
        chk("R10 clk_out held when disabled", clk_out, c0);

        // R13: software write beats increment
        count_wr = 1; count_wdata = 16'h0400;
        step(1);
        count_wr = 0;
        chk("R13 write priority", count_q, 16'h0400);
        step(1);
        chk("R13 count after write", count_q, 16'h0401);
        run_en = 0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule